// File: doc/BRIEF.md
# Interrupt and Exception Entry Controller

This block sits next to a simple 32-bit CPU core. It decides whether a non-maskable interrupt, a maskable interrupt, a software trap or an illegal-opcode event is taken in a cycle. When one is taken, it performs the whole state-saving entry in a single clock and sends the core a one-cycle redirect to that cause's handler.

The block keeps the program status word (PSW), one pair of save registers (saved return PC and saved PSW) and the cause register. A return-from-interrupt strobe restores the PC and the PSW from the save pair. A PSW write strobe stands in for the core's system-register write.

PSW field positions are fixed: ID (interrupts disabled) is bit 5, EP (exception in progress) is bit 6, and NP (NMI in progress) is bit 7. The core sees every result through the registered outputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the redirect strobe, the acknowledge strobe and all of PSW, EIPC, EIPSW and ECR are zero.
- R2: An NMI strobe causes a redirect to 0x00000010 and writes 0x0010 into ECR[31:16]. ECR[15:0], EIPC and EIPSW are left unchanged. The PSW gets NP=1, ID=1 and EP=0.
- R3: A trap strobe with a 5-bit vector v writes 0x0040+v into ECR[15:0]. It redirects to 0x00000040 when v<0x10, and to 0x00000050 otherwise. EIPC receives the next PC, EIPSW receives the old PSW, and the PSW gets EP=1 and ID=1.
- R4: An illegal-opcode strobe writes 0x0060 into ECR[15:0] and redirects to 0x00000060. EIPC receives the current PC plus 4, so EIPC minus 4 is the faulting address. The PSW gets EP=1 and ID=1.
- R5: A taken maskable request does all of the following in one cycle: EIPC receives the next PC, EIPSW receives the old PSW, ECR[15:0] receives the request code, ECR[31:16] is kept, the PSW gets ID=1 and EP=0, the redirect goes to the request's handler address, and the acknowledge strobe pulses.
- R6: A maskable request taken while the divide-busy flag is high saves the current PC into EIPC instead of the next PC.
- R7: A maskable request is not taken, and no redirect occurs, while its mask input is high, while PSW.ID=1, or while PSW.NP=1.
- R8: A request that is still held is taken in the cycle after a PSW write or a return-from-interrupt leaves ID=0 and NP=0.
- R9: EIPC[31:24] and EIPSW[31:8] are always zero.
- R10: When several events arrive in one cycle, the order of priority is NMI, then illegal opcode, then trap, then maskable interrupt. Only the highest one is taken.
- R11: Return-from-interrupt redirects to EIPC and loads the PSW from EIPSW in one cycle.
- R12: There is a single save pair, so a second entry overwrites the EIPC and EIPSW values that the first entry saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_i | input | 1 | NMI strobe |
| irq_req_i | input | 1 | Maskable request, held until acknowledged |
| irq_mask_i | input | 1 | Mask for the maskable request |
| irq_code_i | input | 16 | Cause code of the maskable request |
| irq_handler_i | input | 32 | Handler address of the maskable request |
| trap_i | input | 1 | Software trap strobe |
| trap_vec_i | input | 5 | Trap vector |
| illop_i | input | 1 | Illegal-opcode strobe |
| cur_pc_i | input | 32 | Address of the executing instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| div_busy_i | input | 1 | Divide instruction in progress |
| psw_wr_i | input | 1 | PSW write strobe |
| psw_wdata_i | input | 32 | PSW write data |
| reti_i | input | 1 | Return-from-interrupt strobe |
| redirect_o | output | 1 | One-cycle PC redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| irq_ack_o | output | 1 | Maskable request was taken |
| eipc_o | output | 32 | Saved return PC |
| eipsw_o | output | 32 | Saved PSW |
| ecr_o | output | 32 | Cause register |
| psw_o | output | 32 | Current PSW |

## Verification
Every output is a register. A stimulus applied before a rising edge therefore shows its result exactly one edge later, and only for that one cycle in the case of the redirect and acknowledge strobes. The bench drives inputs on the falling edge and samples on the next falling edge. The gating of a held request reads the PSW from before the edge, so a PSW write or a return takes one edge to land, and the request is taken on the edge after that. The pending-request tests look for the acknowledge at that second sample and nowhere earlier.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              irq_req_i,
  input  logic              irq_mask_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   irq_handler_i,
  input  logic              trap_i,
  input  logic [4:0]        trap_vec_i,
  input  logic              illop_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   next_pc_i,
  input  logic              div_busy_i,
  input  logic              psw_wr_i,
  input  logic [XLEN-1:0]   psw_wdata_i,
  input  logic              reti_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              irq_ack_o,
  output logic [XLEN-1:0]   eipc_o,
  output logic [XLEN-1:0]   eipsw_o,
  output logic [XLEN-1:0]   ecr_o,
  output logic [XLEN-1:0]   psw_o
);
  localparam int ID = 5, EP = 6, NP = 7;
  localparam int PCW = XLEN - 8;

  logic irq_ok, take_nmi, take_ill, take_trap, take_irq, take_sync;
  logic [XLEN-1:0]   ret_pc, vec_pc;
  logic [CODE_W-1:0] code;

  assign irq_ok    = irq_req_i & ~irq_mask_i & ~psw_o[ID] & ~psw_o[NP];
  assign take_nmi  = nmi_i;
  assign take_ill  = ~nmi_i & illop_i;
  assign take_trap = ~nmi_i & ~illop_i & trap_i;
  assign take_irq  = ~nmi_i & ~illop_i & ~trap_i & irq_ok;
  assign take_sync = take_ill | take_trap;

  always_comb begin
    ret_pc = next_pc_i;
    vec_pc = irq_handler_i;
    code   = irq_code_i;
    if (take_ill) begin
      ret_pc = cur_pc_i + XLEN'(4);
      vec_pc = XLEN'(32'h60);
      code   = CODE_W'(16'h0060);
    end else if (take_trap) begin
      vec_pc = trap_vec_i[4] ? XLEN'(32'h50) : XLEN'(32'h40);
      code   = CODE_W'(16'h0040) + CODE_W'(trap_vec_i);
    end else if (take_irq && div_busy_i) begin
      ret_pc = cur_pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      irq_ack_o     <= 1'b0;
      eipc_o        <= '0;
      eipsw_o       <= '0;
      ecr_o         <= '0;
      psw_o         <= '0;
    end else begin
      redirect_o <= take_nmi | take_sync | take_irq | reti_i;
      irq_ack_o  <= take_irq;
      if (take_nmi) begin
        redirect_pc_o        <= XLEN'(32'h10);
        ecr_o[XLEN-1:CODE_W] <= (XLEN-CODE_W)'(16'h0010);
        psw_o[NP]            <= 1'b1;
        psw_o[ID]            <= 1'b1;
        psw_o[EP]            <= 1'b0;
      end else if (take_sync || take_irq) begin
        redirect_pc_o      <= vec_pc;
        eipc_o             <= {8'h00, ret_pc[PCW-1:0]};
        eipsw_o            <= {{(XLEN-8){1'b0}}, psw_o[7:0]};
        ecr_o[CODE_W-1:0]  <= code;
        psw_o[ID]          <= 1'b1;
        psw_o[EP]          <= take_sync;
      end else if (reti_i) begin
        redirect_pc_o <= eipc_o;
        psw_o         <= eipsw_o;
      end else if (psw_wr_i) begin
        psw_o <= psw_wdata_i;
      end
    end
  end

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> ($past(irq_mask_i) == 1'b0 && $past(psw_o[ID]) == 1'b0 && $past(psw_o[NP]) == 1'b0));

  p_irq_psw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (psw_o[ID] && !psw_o[EP] && redirect_o));

  p_nmi_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nmi_i)) |-> (redirect_o && redirect_pc_o == XLEN'(32'h10) && psw_o[NP]));

  p_div_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && $past(div_busy_i)) |-> (eipc_o[PCW-1:0] == $past(cur_pc_i[PCW-1:0])));

  p_save_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect_o) |-> (eipc_o[XLEN-1:PCW] == 8'h00 && eipsw_o[XLEN-1:8] == '0));

  p_reti_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reti_i) && !$past(nmi_i | illop_i | trap_i | irq_ok))
      |-> (psw_o == $past(eipsw_o) && redirect_pc_o == $past(eipc_o)));
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 0, rst_n = 0;
  logic nmi_i = 0, irq_req_i = 0, irq_mask_i = 0, trap_i = 0, illop_i = 0;
  logic div_busy_i = 0, psw_wr_i = 0, reti_i = 0;
  logic [15:0] irq_code_i = 0;
  logic [31:0] irq_handler_i = 0, cur_pc_i = 0, next_pc_i = 0, psw_wdata_i = 0;
  logic [4:0]  trap_vec_i = 0;
  logic redirect_o, irq_ack_o;
  logic [31:0] redirect_pc_o, eipc_o, eipsw_o, ecr_o, psw_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    nmi_i = 0; trap_i = 0; illop_i = 0; psw_wr_i = 0; reti_i = 0;
  endtask

  task automatic wr_psw(input logic [31:0] v);
    psw_wr_i = 1; psw_wdata_i = v; step(); psw_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 redirect", {31'b0, redirect_o}, 0);
    chk("R1 ack", {31'b0, irq_ack_o}, 0);
    chk("R1 psw", psw_o, 0);
    chk("R1 eipc", eipc_o, 0);
    chk("R1 eipsw", eipsw_o, 0);
    chk("R1 ecr", ecr_o, 0);
  endtask

  task automatic t_irq_basic();
    wr_psw(32'h0000_000F);
    irq_req_i = 1; irq_code_i = 16'h0080; irq_handler_i = 32'h0000_0100;
    next_pc_i = 32'h1234_5678; cur_pc_i = 32'h1234_5674;
    step(); irq_req_i = 0;
    chk("R5 redirect", {31'b0, redirect_o}, 1);
    chk("R5 ack", {31'b0, irq_ack_o}, 1);
    chk("R5 target", redirect_pc_o, 32'h100);
    chk("R5 R9 eipc", eipc_o, 32'h0034_5678);
    chk("R5 eipsw", eipsw_o, 32'h0F);
    chk("R5 ecr", ecr_o, 32'h0000_0080);
    chk("R5 psw", psw_o, 32'h2F);
    step();
    chk("R5 single pulse", {31'b0, redirect_o}, 0);
  endtask

  task automatic t_blocked();
    irq_req_i = 1; irq_code_i = 16'h0090;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R7 held by ID", {31'b0, redirect_o | irq_ack_o}, 0);
    end
    wr_psw(32'h0);
    chk("R8 not yet after write", {31'b0, irq_ack_o}, 0);
    step(); irq_req_i = 0;
    chk("R8 taken after write", {31'b0, irq_ack_o}, 1);
    chk("R8 ecr", ecr_o[15:0], 16'h0090);
    wr_psw(32'h0);
    irq_mask_i = 1; irq_req_i = 1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R7 held by mask", {31'b0, redirect_o | irq_ack_o}, 0);
    end
    irq_mask_i = 0; irq_req_i = 0;
    wr_psw(32'h80); irq_req_i = 1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R7 held by NP", {31'b0, redirect_o | irq_ack_o}, 0);
    end
    irq_req_i = 0;
    chk("R7 psw kept", psw_o, 32'h80);
  endtask

  task automatic t_reti();
    wr_psw(32'h0000_0003);
    irq_req_i = 1; irq_code_i = 16'h00A0; irq_handler_i = 32'h200; next_pc_i = 32'h0000_3000;
    step(); irq_req_i = 0;
    chk("R5 second entry", eipsw_o, 32'h03);
    irq_req_i = 1; irq_code_i = 16'h00A4;
    step(); chk("R7 held during handler", {31'b0, irq_ack_o}, 0);
    reti_i = 1; step(); reti_i = 0;
    chk("R11 redirect", {31'b0, redirect_o}, 1);
    chk("R11 target", redirect_pc_o, 32'h3000);
    chk("R11 psw", psw_o, 32'h03);
    step(); irq_req_i = 0;
    chk("R8 taken after reti", {31'b0, irq_ack_o}, 1);
    chk("R8 code after reti", ecr_o[15:0], 16'h00A4);
  endtask

  task automatic t_div();
    wr_psw(32'h0);
    div_busy_i = 1; cur_pc_i = 32'h0000_0400; next_pc_i = 32'h0000_0404;
    irq_req_i = 1; step(); irq_req_i = 0; div_busy_i = 0;
    chk("R6 eipc divide", eipc_o, 32'h400);
  endtask

  task automatic t_traps();
    wr_psw(32'h0000_0001);
    next_pc_i = 32'h0000_5004; trap_i = 1; trap_vec_i = 5'h03; step(); trap_i = 0;
    chk("R3 code low", ecr_o[15:0], 16'h0043);
    chk("R3 target low", redirect_pc_o, 32'h40);
    chk("R3 eipc", eipc_o, 32'h5004);
    chk("R3 eipsw", eipsw_o, 32'h01);
    chk("R3 psw", psw_o, 32'h61);
    next_pc_i = 32'h0000_6008; trap_i = 1; trap_vec_i = 5'h1A; step(); trap_i = 0;
    chk("R3 code high", ecr_o[15:0], 16'h005A);
    chk("R3 target high", redirect_pc_o, 32'h50);
    chk("R12 eipc overwritten", eipc_o, 32'h6008);
    chk("R12 eipsw overwritten", eipsw_o, 32'h61);
  endtask

  task automatic t_illop();
    wr_psw(32'hFFFF_FF00);
    cur_pc_i = 32'hAB00_2000; illop_i = 1; step(); illop_i = 0;
    chk("R4 code", ecr_o[15:0], 16'h0060);
    chk("R4 target", redirect_pc_o, 32'h60);
    chk("R4 R9 eipc", eipc_o, 32'h0000_2004);
    chk("R9 eipsw upper", eipsw_o, 32'h0000_0000);
    chk("R4 psw", psw_o, 32'hFFFF_FF60);
  endtask

  task automatic t_nmi();
    logic [31:0] pc0, sw0;
    wr_psw(32'h0);
    pc0 = eipc_o; sw0 = eipsw_o;
    nmi_i = 1; step(); nmi_i = 0;
    chk("R2 target", redirect_pc_o, 32'h10);
    chk("R2 ecr", ecr_o, 32'h0010_0060);
    chk("R2 eipc kept", eipc_o, pc0);
    chk("R2 eipsw kept", eipsw_o, sw0);
    chk("R2 psw", psw_o, 32'hA0);
    wr_psw(32'h0); trap_i = 1; trap_vec_i = 5'h01; step(); trap_i = 0;
    chk("R3 ecr upper kept", ecr_o, 32'h0010_0041);
  endtask

  task automatic t_priority();
    wr_psw(32'h0);
    nmi_i = 1; illop_i = 1; trap_i = 1; irq_req_i = 1; trap_vec_i = 5'h02;
    step(); clear_strobes(); irq_req_i = 0;
    chk("R10 nmi wins", redirect_pc_o, 32'h10);
    chk("R10 no ack", {31'b0, irq_ack_o}, 0);
    wr_psw(32'h0);
    illop_i = 1; trap_i = 1; step(); clear_strobes();
    chk("R10 illop over trap", redirect_pc_o, 32'h60);
    wr_psw(32'h0);
    trap_i = 1; irq_req_i = 1; step(); clear_strobes(); irq_req_i = 0;
    chk("R10 trap over irq", redirect_pc_o, 32'h40);
    chk("R10 trap no ack", {31'b0, irq_ack_o}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_irq_basic();
        t_blocked();
        t_reti();
        t_div();
        t_traps();
        t_illop();
        t_nmi();
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule